// File: doc/BRIEF.md
# USB Controller Wrapper Interrupt Register Block

This block is the register shell placed around a dual-role USB controller core. It collects per-endpoint and core-level interrupt sources into two latched pending words, each guarded by its own enable mask, and drives a single combined interrupt line toward the system interrupt controller. Pending bits latch on the rising edge of their source and are cleared by software writing ones. Enable masks are changed through a pair of addresses per group, one that sets bits and one that clears them, so software never needs a read-modify-write on the mask.

Alongside the interrupt logic the block holds a fixed revision word, a control word whose bit 0 pulses a one-cycle soft reset to the wrapped core, a read-only status word that shows the core's VBUS-drive level, a PHY control word whose bit 21 disables the PHY's OTG function, and a mode word that lets software override the ID pin seen by the core. Accesses come over a plain 32-bit register bus with an 8-bit byte address, a write strobe and a combinational read path.

Top module: `usb_wrap_regs`

## Requirements
- R1: Address 0x00 reads the non-zero REVISION parameter (default 0x4EA2_0800); writes there change nothing.
- R2: In the endpoint pending word (read at 0x30) bits 15:0 latch rising edges of transmit endpoint sources 0..15, bits 31:17 latch rising edges of receive endpoint sources 1..15, and bit 16 never sets; the core pending word (read at 0x34) latches rising edges of core sources in bits 8:0, bit 8 being the VBUS-drive change event. A latched bit stays set after its source falls.
- R3: Writing a 1 to a bit of 0x30 or 0x34 clears that pending bit and writing 0 leaves it; if the source of that bit rises in the same cycle as the clear, the bit stays set.
- R4: Writing 1s to 0x38 (endpoint) or 0x3C (core) sets those enable bits; writing 1s to 0x40 or 0x44 clears them; 0x38 and 0x3C read the current mask, 0x40 and 0x44 read zero, and endpoint enable bit 16 and core enable bits 31:9 never set.
- R5: `irq` is a register: in the cycle after any edge where some pending bit with its enable set exists it is 1, otherwise 0.
- R6: Writing 0x14 with bit 0 set drives `core_soft_reset` high for exactly the next cycle, during which 0x14 reads 1; otherwise it is low and 0x14 reads 0.
- R7: Address 0x18 reads `vbus_drv_lvl` in bit 0 and zero elsewhere; writes there change nothing.
- R8: Address 0xE0 is a full 32-bit read/write PHY control word that resets to 0x0020_0000; `phy_ctrl` shows it and `otg_disable` equals its bit 21.
- R9: Address 0xE8 keeps only bit 8 (software ID) and bit 7 (ID select); other bits read zero; `id_out` equals bit 8 when bit 7 is 1 and `phy_id_in` otherwise.
- R10: After reset both pending words, both masks, the mode word and `irq` are zero; unmapped addresses read zero and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_ep_src | input | 16 | Transmit endpoint interrupt sources 0..15 |
| rx_ep_src | input | 15 | Receive endpoint interrupt sources 1..15 |
| core_src | input | 9 | Core interrupt sources, bit 8 the VBUS-drive change |
| vbus_drv_lvl | input | 1 | Current VBUS-drive level from the core |
| phy_id_in | input | 1 | ID pin level reported by the PHY |
| irq | output | 1 | Combined registered interrupt |
| core_soft_reset | output | 1 | One-cycle reset pulse to the wrapped core |
| phy_ctrl | output | 32 | PHY control word |
| otg_disable | output | 1 | PHY OTG disable control |
| id_out | output | 1 | Effective ID level delivered to the core |

## Verification
On every cycle the assertions check that a source edge leaves its pending bit set, that a write-one clear removes every cleared bit without a competing edge, that mask set and clear writes take effect, that `irq` follows the enabled pending state one cycle later, that the soft-reset pulse never lasts two cycles by itself, and that the PHY and mode words hold when not written. The address map itself, reserved bits reading zero, the clear-against-event race, the read-only words ignoring writes and the ID override only show up in the bench's directed scenarios and in its random register traffic compared against a behavioural model.

// File: rtl/usbw_pkg.sv
// Package: shared register offsets, bit positions and the per-group
// write-strobe bundle for the USB wrapper register block.
// Assumes an 8-bit byte address and 32-bit data words.
package usbw_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    // Byte offsets; software drivers depend on these positions.
    localparam logic [ADDR_W-1:0] OFS_REV    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_EP_ST  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_CO_ST  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_EP_SET = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_CO_SET = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_EP_CLR = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CO_CLR = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_PHY    = 8'hE0;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'hE8;

    // Bit positions inside individual words.
    localparam int unsigned CTRL_SRST_BIT  = 0;
    localparam int unsigned MODE_SEL_BIT   = 7;
    localparam int unsigned MODE_SWID_BIT  = 8;
    localparam int unsigned PHY_OTGDIS_BIT = 21;

    // Write strobes delivered to one interrupt group.
    typedef struct packed {
        logic clr_pend;   // write-one-to-clear on the pending word
        logic en_set;     // write-one-to-set on the enable mask
        logic en_clr;     // write-one-to-clear on the enable mask
    } grp_wr_t;

endpackage

// File: rtl/usbw_irq_group.sv
// Module: one interrupt group (pending word plus enable mask).
// Pending bits latch on a rising source edge and clear on a write of
// ones; a new edge wins over a clear in the same cycle. The enable mask
// is changed through separate set and clear strobes. Bits outside VALID
// never set. Assumes sources are already synchronous to clk.
module usbw_irq_group
    import usbw_pkg::*;
#(
    parameter int unsigned W     = 9,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src,
    input  grp_wr_t       wr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  pend_q,
    output logic [W-1:0]  enab_q,
    output logic          active
);

    logic [W-1:0] src_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_vec;

    // Edge and clear vectors for this cycle.
    always_comb begin
        rise    = src & ~src_q & VALID;
        clr_vec = wr.clr_pend ? (wdata & VALID) : '0;
    end

    // Source history, pending latch and enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
            enab_q <= '0;
        end else begin
            src_q  <= src;
            pend_q <= ((pend_q & ~clr_vec) | rise) & VALID;
            if (wr.en_set)
                enab_q <= (enab_q | wdata) & VALID;
            else if (wr.en_clr)
                enab_q <= enab_q & ~wdata;
        end
    end

    // Group request: some pending bit that is enabled.
    assign active = |(pend_q & enab_q);

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));           // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr.clr_pend |=> ((pend_q & $past(clr_vec & ~rise)) == '0));     // R3
    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr.en_set |=> ((enab_q & $past(wdata & VALID)) == $past(wdata & VALID))); // R4
    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.en_clr && !wr.en_set) |=> ((enab_q & $past(wdata)) == '0)); // R4

endmodule

// File: rtl/usbw_cfg_regs.sv
// Module: control-side registers of the USB wrapper: self-clearing soft
// reset, PHY control word and the ID override mode bits.
// Assumes at most one write strobe is active per cycle.
module usbw_cfg_regs
    import usbw_pkg::*;
#(
    parameter logic [DATA_W-1:0] PHY_RESET = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              srst_bit,
    input  logic              phy_we,
    input  logic [DATA_W-1:0] phy_wdata,
    input  logic              mode_we,
    input  logic              mode_sel_bit,
    input  logic              mode_swid_bit,
    input  logic              phy_id_in,
    output logic              soft_rst_q,
    output logic [DATA_W-1:0] phy_q,
    output logic              sel_q,
    output logic              swid_q,
    output logic              id_out
);

    // Soft reset pulse: set by a write of 1, gone the cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_q <= 1'b0;
        else        soft_rst_q <= ctrl_we && srst_bit;
    end

    // PHY control word, full width writable.
    always_ff @(posedge clk) begin
        if (!rst_n)      phy_q <= PHY_RESET;
        else if (phy_we) phy_q <= phy_wdata;
    end

    // Mode bits: ID select and software ID value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            swid_q <= 1'b0;
        end else if (mode_we) begin
            sel_q  <= mode_sel_bit;
            swid_q <= mode_swid_bit;
        end
    end

    // Effective ID: software value when selected, PHY pin otherwise.
    assign id_out = sel_q ? swid_q : phy_id_in;

    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_q && !(ctrl_we && srst_bit)) |=> !soft_rst_q);        // R6
    AST_PHY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_we |=> $stable(phy_q));                                    // R8
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> ($stable(sel_q) && $stable(swid_q)));              // R9

endmodule

// File: rtl/usb_wrap_regs.sv
// Module: top of the USB wrapper register block. Decodes the register
// bus, hosts the endpoint and core interrupt groups and the control
// registers, and registers the combined interrupt line.
// Assumes TX_EPS + RX_EPS equals the 32-bit data width and CORE_W < 32.
module usb_wrap_regs
    import usbw_pkg::*;
#(
    parameter int unsigned       TX_EPS    = 16,
    parameter int unsigned       RX_EPS    = 16,
    parameter int unsigned       CORE_W    = 9,
    parameter logic [31:0]       REVISION  = 32'h4EA2_0800,
    parameter logic [31:0]       PHY_RESET = 32'h0020_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [TX_EPS-1:0]    tx_ep_src,
    input  logic [RX_EPS-1:1]    rx_ep_src,
    input  logic [CORE_W-1:0]    core_src,
    input  logic                 vbus_drv_lvl,
    input  logic                 phy_id_in,
    output logic                 irq,
    output logic                 core_soft_reset,
    output logic [31:0]          phy_ctrl,
    output logic                 otg_disable,
    output logic                 id_out
);

    localparam int unsigned      EP_W     = TX_EPS + RX_EPS;
    localparam logic [EP_W-1:0]  EP_VALID = {{(RX_EPS-1){1'b1}}, 1'b0, {TX_EPS{1'b1}}};
    localparam logic [CORE_W-1:0] CO_VALID = '1;
    localparam int unsigned      CO_PAD   = DATA_W - CORE_W;

    grp_wr_t             ep_wr, co_wr;
    logic [EP_W-1:0]     ep_src, ep_pend, ep_enab;
    logic [CORE_W-1:0]   co_pend, co_enab;
    logic                ep_active, co_active;
    logic                sel_q, swid_q;

    // Endpoint source word: receive endpoint 0 has no source.
    assign ep_src = {rx_ep_src, 1'b0, tx_ep_src};

    // Write decode into per-group strobes.
    always_comb begin
        ep_wr.clr_pend = bus_we && (bus_addr == OFS_EP_ST);
        ep_wr.en_set   = bus_we && (bus_addr == OFS_EP_SET);
        ep_wr.en_clr   = bus_we && (bus_addr == OFS_EP_CLR);
        co_wr.clr_pend = bus_we && (bus_addr == OFS_CO_ST);
        co_wr.en_set   = bus_we && (bus_addr == OFS_CO_SET);
        co_wr.en_clr   = bus_we && (bus_addr == OFS_CO_CLR);
    end

    usbw_irq_group #(.W(EP_W), .VALID(EP_VALID)) u_ep_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (ep_src),
        .wr     (ep_wr),
        .wdata  (bus_wdata[EP_W-1:0]),
        .pend_q (ep_pend),
        .enab_q (ep_enab),
        .active (ep_active)
    );

    usbw_irq_group #(.W(CORE_W), .VALID(CO_VALID)) u_core_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (core_src),
        .wr     (co_wr),
        .wdata  (bus_wdata[CORE_W-1:0]),
        .pend_q (co_pend),
        .enab_q (co_enab),
        .active (co_active)
    );

    usbw_cfg_regs #(.PHY_RESET(PHY_RESET)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we       (bus_we && (bus_addr == OFS_CTRL)),
        .srst_bit      (bus_wdata[CTRL_SRST_BIT]),
        .phy_we        (bus_we && (bus_addr == OFS_PHY)),
        .phy_wdata     (bus_wdata),
        .mode_we       (bus_we && (bus_addr == OFS_MODE)),
        .mode_sel_bit  (bus_wdata[MODE_SEL_BIT]),
        .mode_swid_bit (bus_wdata[MODE_SWID_BIT]),
        .phy_id_in     (phy_id_in),
        .soft_rst_q    (core_soft_reset),
        .phy_q         (phy_ctrl),
        .sel_q         (sel_q),
        .swid_q        (swid_q),
        .id_out        (id_out)
    );

    assign otg_disable = phy_ctrl[PHY_OTGDIS_BIT];

    // Combined interrupt, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= ep_active || co_active;
    end

    // Read mux; unmapped addresses and reserved bits return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REV:    bus_rdata = REVISION;
            OFS_CTRL:   bus_rdata[CTRL_SRST_BIT] = core_soft_reset;
            OFS_STAT:   bus_rdata[0] = vbus_drv_lvl;
            OFS_EP_ST:  bus_rdata = ep_pend;
            OFS_CO_ST:  bus_rdata = {{CO_PAD{1'b0}}, co_pend};
            OFS_EP_SET: bus_rdata = ep_enab;
            OFS_CO_SET: bus_rdata = {{CO_PAD{1'b0}}, co_enab};
            OFS_PHY:    bus_rdata = phy_ctrl;
            OFS_MODE: begin
                bus_rdata[MODE_SEL_BIT]  = sel_q;
                bus_rdata[MODE_SWID_BIT] = swid_q;
            end
            default:    bus_rdata = '0;
        endcase
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_active || co_active) |=> irq);                              // R5
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ep_active || co_active) |=> !irq);                            // R5
    AST_RX0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        ep_wr.en_set |=> !ep_enab[TX_EPS]);                             // R4

endmodule

// File: tb/usb_wrap_regs_bench.sv
// Bench: directed corner cases plus seeded random register traffic,
// compared against a behavioural model written from the requirements.
module usb_wrap_regs_bench;

    localparam logic [31:0] REV_EXP  = 32'h4EA2_0800;
    localparam logic [31:0] EP_VALID = 32'hFFFE_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tx_ep_src = '0;
    logic [15:1] rx_ep_src = '0;
    logic [8:0]  core_src = '0;
    logic        vbus_drv_lvl = 1'b0;
    logic        phy_id_in = 1'b0;
    logic        irq, core_soft_reset, otg_disable, id_out;
    logic [31:0] phy_ctrl;

    always #4 clk = ~clk;   // 125 MHz

    usb_wrap_regs u_usb_wrap_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_ep_src(tx_ep_src), .rx_ep_src(rx_ep_src), .core_src(core_src),
        .vbus_drv_lvl(vbus_drv_lvl), .phy_id_in(phy_id_in), .irq(irq),
        .core_soft_reset(core_soft_reset), .phy_ctrl(phy_ctrl),
        .otg_disable(otg_disable), .id_out(id_out)
    );

    // Stimulus variables and model state.
    logic [15:0] tx_v = '0;
    logic [15:1] rx_v = '0;
    logic [8:0]  co_v = '0;
    logic        vb_v = 1'b0, pid_v = 1'b0;
    logic [31:0] m_ep, m_epen, m_ep_prev, m_phy;
    logic [8:0]  m_co, m_coen, m_co_prev;
    logic        m_irq, m_srst, m_sel, m_swid;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    task automatic model_reset();
        m_ep = '0; m_epen = '0; m_ep_prev = '0; m_phy = 32'h0020_0000;
        m_co = '0; m_coen = '0; m_co_prev = '0;
        m_irq = 1'b0; m_srst = 1'b0; m_sel = 1'b0; m_swid = 1'b0;
    endtask

    // One clock edge of the required behaviour.
    task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] ev, eclr;
        logic [8:0]  cclr;
        ev   = {rx_v, 1'b0, tx_v};
        eclr = (we && a == 8'h30) ? d : '0;
        cclr = (we && a == 8'h34) ? d[8:0] : '0;
        m_irq  = (|(m_ep & m_epen)) || (|(m_co & m_coen));
        m_srst = we && (a == 8'h14) && d[0];
        m_ep = ((m_ep & ~eclr) | (ev & ~m_ep_prev)) & EP_VALID;
        m_co = (m_co & ~cclr) | (co_v & ~m_co_prev);
        m_ep_prev = ev;
        m_co_prev = co_v;
        if (we) begin
            case (a)
                8'h38: m_epen = (m_epen | d) & EP_VALID;
                8'h40: m_epen = m_epen & ~d;
                8'h3C: m_coen = m_coen | d[8:0];
                8'h44: m_coen = m_coen & ~d[8:0];
                8'hE0: m_phy  = d;
                8'hE8: begin m_sel = d[7]; m_swid = d[8]; end
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return REV_EXP;
            8'h14: return {31'd0, m_srst};
            8'h18: return {31'd0, vb_v};
            8'h30: return m_ep;
            8'h34: return {23'd0, m_co};
            8'h38: return m_epen;
            8'h3C: return {23'd0, m_coen};
            8'hE0: return m_phy;
            8'hE8: return {23'd0, m_swid, m_sel, 7'd0};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R1";
            8'h14: return "R6";
            8'h18: return "R7";
            8'h30, 8'h34: return "R2";
            8'h38, 8'h3C, 8'h40, 8'h44: return "R4";
            8'hE0: return "R8";
            8'hE8: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [7:0] pick_addr(input int unsigned k);
        case (k % 12)
            0: return 8'h00;  1: return 8'h14;  2: return 8'h18;  3: return 8'h30;
            4: return 8'h34;  5: return 8'h38;  6: return 8'h3C;  7: return 8'h40;
            8: return 8'h44;  9: return 8'hE0;  10: return 8'hE8; default: return 8'h20;
        endcase
    endfunction

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle away from the edge, advance the model, then compare.
    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                        input string tag);
        string t;
        t = (tag == "") ? tag_of(a) : tag;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        tx_ep_src = tx_v; rx_ep_src = rx_v; core_src = co_v;
        vbus_drv_lvl = vb_v; phy_id_in = pid_v;
        @(posedge clk);
        model_edge(we, a, d);
        #2;
        check_eq(t, "rdata", bus_rdata, exp_read(a));
        check_eq("R5", "irq", {31'd0, irq}, {31'd0, m_irq});
        check_eq("R6", "core_soft_reset", {31'd0, core_soft_reset}, {31'd0, m_srst});
        check_eq("R8", "phy_ctrl", phy_ctrl, m_phy);
        check_eq("R8", "otg_disable", {31'd0, otg_disable}, {31'd0, m_phy[21]});
        check_eq("R9", "id_out", {31'd0, id_out}, {31'd0, m_sel ? m_swid : pid_v});
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state of every word, read without writes.
        step(0, 8'h00, '0, "R1");
        step(0, 8'h30, '0, "R10");
        step(0, 8'h34, '0, "R10");
        step(0, 8'h38, '0, "R10");
        step(0, 8'hE8, '0, "R10");
        step(0, 8'hE0, '0, "R8");
        check_eq("R10", "irq after reset", {31'd0, irq}, 32'd0);

        // R1: revision ignores writes and is non-zero.
        step(1, 8'h00, 32'hFFFF_FFFF, "R1");
        check_eq("R1", "revision nonzero", {31'd0, bus_rdata != 0}, 32'd1);

        // R2: tx ep 3 and rx ep 5 rise; bit 16 has no source.
        tx_v = 16'h0008; rx_v = 15'h0010;
        step(0, 8'h30, '0, "R2");
        check_eq("R2", "ep word layout", bus_rdata, 32'h0020_0008);
        tx_v = '0; rx_v = '0;
        step(0, 8'h30, '0, "R2");   // stays latched after sources fall

        // R3: zero write keeps, partial one write clears.
        step(1, 8'h30, 32'h0000_0000, "R3");
        step(1, 8'h30, 32'h0000_0008, "R3");
        check_eq("R3", "cleared bit3 only", bus_rdata, 32'h0020_0000);
        // R3: edge on bit 4 in the same cycle as its clear wins.
        tx_v = 16'h0010; step(0, 8'h30, '0, "R3");
        tx_v = '0;       step(0, 8'h30, '0, "R3");
        tx_v = 16'h0010; step(1, 8'h30, 32'h0000_0010, "R3");
        check_eq("R3", "event beats clear", bus_rdata & 32'h10, 32'h10);
        tx_v = '0;
        step(1, 8'h30, 32'hFFFF_FFFF, "R3");

        // R4: set/clear enables, clear address reads zero, bit 16 stuck low.
        step(1, 8'h38, 32'hFFFF_FFFF, "R4");
        check_eq("R4", "ep enable mask", bus_rdata, 32'hFFFE_FFFF);
        step(1, 8'h40, 32'h0000_FFFF, "R4");
        step(0, 8'h38, '0, "R4");
        step(0, 8'h40, '0, "R4");
        step(1, 8'h3C, 32'hFFFF_FFFF, "R4");
        check_eq("R4", "core enable mask", bus_rdata, 32'h0000_01FF);

        // R5: VBUS-drive event (core bit 8) enabled -> irq one cycle later.
        step(1, 8'h44, 32'h0000_00FF, "R4");
        co_v = 9'h100; step(0, 8'h34, '0, "R2");
        check_eq("R2", "vbus change latched", bus_rdata, 32'h0000_0100);
        step(0, 8'h34, '0, "R5");
        check_eq("R5", "irq raised", {31'd0, irq}, 32'd1);
        step(1, 8'h34, 32'h0000_0100, "R5");
        check_eq("R5", "irq still high in clear cycle", {31'd0, irq}, 32'd1);
        step(0, 8'h34, '0, "R5");
        check_eq("R5", "irq dropped", {31'd0, irq}, 32'd0);
        co_v = '0;

        // R6: soft reset pulse lasts one cycle.
        step(1, 8'h14, 32'h0000_0001, "R6");
        check_eq("R6", "pulse high", {31'd0, core_soft_reset}, 32'd1);
        step(0, 8'h14, '0, "R6");
        check_eq("R6", "pulse gone", {31'd0, core_soft_reset}, 32'd0);

        // R7: status word shows VBUS level, ignores writes.
        vb_v = 1'b1; step(1, 8'h18, 32'hFFFF_FFFE, "R7");
        vb_v = 1'b0; step(0, 8'h18, '0, "R7");

        // R8: PHY word write/read, OTG disable bit cleared.
        step(1, 8'hE0, 32'h0000_0002, "R8");
        check_eq("R8", "otg disable cleared", {31'd0, otg_disable}, 32'd0);

        // R9: ID override and return to the PHY pin.
        pid_v = 1'b0; step(1, 8'hE8, 32'hFFFF_FFFF, "R9");
        check_eq("R9", "forced id", {31'd0, id_out}, 32'd1);
        step(1, 8'hE8, 32'h0000_0080, "R9");
        check_eq("R9", "forced id low", {31'd0, id_out}, 32'd0);
        pid_v = 1'b1; step(1, 8'hE8, 32'h0000_0100, "R9");
        check_eq("R9", "pin id", {31'd0, id_out}, 32'd1);

        // R10: unmapped address reads zero after a write.
        step(1, 8'h20, 32'hDEAD_BEEF, "R10");
        step(0, 8'h24, '0, "R10");

        // Random traffic: sparse source toggles, random register writes.
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            tx_v  = tx_v ^ 16'($urandom & $urandom & $urandom);
            rx_v  = rx_v ^ 15'($urandom & $urandom & $urandom);
            co_v  = co_v ^ 9'($urandom & $urandom);
            vb_v  = 1'($urandom);
            pid_v = 1'($urandom);
            a = pick_addr($urandom);
            step(1'($urandom % 3 == 0), a, $urandom, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule